// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives the serial clock of an SPI engine from the core clock. An 8-bit divider code comes from the interface configuration. A static format input chooses between two readings of that code. In the extended reading the divisor is a 4-bit linear factor shifted left by a 3-bit exponent. In the legacy reading the code holds half of an even divisor between 4 and 30, with an offset of 16.

The SPI engine pulses `word_start` when a word begins. At that moment the prescaler captures the decoded divisor and restarts its phase counter. The serial clock starts at its low level. It then alternates between a low phase of ceil(N/2) core cycles and a high phase of floor(N/2) core cycles. A one-cycle strobe marks every edge of the serial clock, so the shift register can act on it. Lowering `run` returns the clock to idle at once.

Top module: `sclk_prescaler`

## Requirements
- R1: After reset, `sclk` and `sclk_tick` are both low.
- R2: With `fmt_ext`=1 the divisor is N = F << E. F is `div_code[3:0]`. E is the 3-bit value {`div_code[7]`, `div_code[6]`, `div_code[4]`}, with `div_code[4]` as its least significant bit. `div_code[5]` has no effect.
- R3: With `fmt_ext`=1, an F of 0 or 1 is used as 2.
- R4: With `fmt_ext`=0 and `div_code[4]`=1, the divisor is N = 2 × `div_code[3:0]`. `div_code[7:5]` has no effect.
- R5: With `fmt_ext`=0, a code with `div_code[4]`=0 or with `div_code[3:0]` below 2 gives N = 4.
- R6: After the `word_start` edge, `sclk` is low for ceil(N/2) cycles and then high for floor(N/2) cycles, repeating. The period is exactly N core cycles.
- R7: `sclk_tick` is high for one cycle in exactly the cycles where `sclk` has just taken a new value.
- R8: `div_code` and `fmt_ext` are sampled only at a `word_start` edge. Changes in the middle of a word do not alter the timing of that word.
- R9: At an edge where `run` is low, `sclk` goes low and no tick is produced, even if a toggle was due at that edge.
- R10: A `word_start` with `run` high restarts the low phase. At that edge it overrides any toggle that was due.
- R11: The extended code 0xDF gives the largest divisor, 1920, with phases of 960 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_ext | input | 1 | Code format: 1 extended, 0 legacy |
| div_code | input | 8 | Divider code from configuration |
| word_start | input | 1 | One-cycle pulse at the start of a word; captures the code |
| run | input | 1 | High while the serial clock should run |
| sclk_tick | output | 1 | One-cycle strobe marking each serial clock edge |
| sclk | output | 1 | Serial clock level, idle low |

## Verification
A toggle that falls due can share a clock edge with either a new `word_start` or a falling `run`. The bench provokes both collisions. It holds each word for exactly the sum of its expected phases plus the next phase, less one cycle, and then issues the restart or lowers `run` for the edge where the next toggle would land. A scoreboard holds the expected gap between strobes and the `sclk` level after each strobe. If a strobe escapes at the collision edge, it appears with a zero gap or with an empty queue, and the scoreboard reports it.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int CODE_W   = 8;
  localparam int SPR_W    = 4;
  localparam int SPPR_W   = 3;
  localparam int DIV_W    = SPR_W + (2**SPPR_W) - 1;
  localparam int CNT_W    = DIV_W - 1;
  localparam int EXP_B0   = 4;
  localparam int EXP_HI   = 6;
  localparam int LEG_FLAG = 4;

  typedef enum logic {FMT_LEGACY = 1'b0, FMT_EXT = 1'b1} fmt_e;

  localparam logic [DIV_W-1:0] DIV_RST     = DIV_W'(4);
  localparam logic [DIV_W-1:0] DIV_LEG_MIN = DIV_W'(4);
  localparam logic [SPR_W-1:0] SPR_MIN     = SPR_W'(2);
endpackage

// File: rtl/presc_code_decode.sv
module presc_code_decode
  import spi_presc_pkg::*;
#(
  parameter bit HAS_LEGACY = 1'b1
) (
  input  logic              fmt_ext,
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div_n
);
  logic [SPR_W-1:0]  spr_raw;
  logic [SPR_W-1:0]  spr_eff;
  logic [SPPR_W-1:0] sppr;
  logic [DIV_W-1:0]  ext_div;
  logic              unused_code5;

  assign unused_code5 = code[5];
  assign spr_raw      = code[SPR_W-1:0];
  assign sppr         = {code[EXP_HI+1:EXP_HI], code[EXP_B0]};

  always_comb begin
    spr_eff = (spr_raw < SPR_MIN) ? SPR_MIN : spr_raw;
    ext_div = {{(DIV_W-SPR_W){1'b0}}, spr_eff} << sppr;
  end

  generate
    if (HAS_LEGACY) begin : g_legacy
      logic             half_ok;
      logic [DIV_W-1:0] leg_div;
      always_comb begin
        half_ok = code[LEG_FLAG] && (code[3:1] != 3'd0);
        leg_div = half_ok ? {{(DIV_W-5){1'b0}}, code[3:0], 1'b0} : DIV_LEG_MIN;
        div_n   = (fmt_e'(fmt_ext) == FMT_EXT) ? ext_div : leg_div;
      end
    end else begin : g_ext_only
      logic unused_fmt;
      assign unused_fmt = fmt_ext;
      assign div_n      = ext_div;
    end
  endgenerate
endmodule

// File: rtl/presc_shadow.sv
module presc_shadow
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_start,
  input  logic [DIV_W-1:0] div_in,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    div_d = word_start ? div_in : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= DIV_RST;
    else        div_q <= div_d;
  end

  assign lo_len = CNT_W'((div_q + DIV_W'(1)) >> 1);
  assign hi_len = CNT_W'(div_q >> 1);

  p_hold_midword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_start |=> $stable(div_q));

  p_div_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(2)) && (div_q <= DIV_W'(1920)));
endmodule

// File: rtl/presc_phase_gen.sv
module presc_phase_gen
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             word_start,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output logic             sclk,
  output logic             sclk_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             tick_q, tick_d;
  logic [CNT_W-1:0] cur_len;
  logic             phase_end;

  assign cur_len   = lvl_q ? hi_len : lo_len;
  assign phase_end = (cnt_q == cur_len - CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    tick_d = 1'b0;
    if (!run || word_start) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (phase_end) begin
      cnt_d  = '0;
      lvl_d  = ~lvl_q;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
    end
  end

  assign sclk      = lvl_q;
  assign sclk_tick = tick_q;

  p_tick_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_tick |-> (sclk != $past(sclk)));

  p_quiet_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_tick && $past(run) && !$past(word_start)) |-> $stable(sclk));

  p_run_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk && !sclk_tick));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && word_start) |=> (!sclk && !sclk_tick));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_len);
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import spi_presc_pkg::*;
#(
  parameter bit HAS_LEGACY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_ext,
  input  logic [CODE_W-1:0] div_code,
  input  logic              word_start,
  input  logic              run,
  output logic              sclk_tick,
  output logic              sclk
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [DIV_W-1:0] div_n;
  logic [CNT_W-1:0] lo_len;
  logic [CNT_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  presc_code_decode #(.HAS_LEGACY(HAS_LEGACY)) u_dec (
    .fmt_ext (fmt_ext),
    .code    (div_code),
    .div_n   (div_n)
  );

  presc_shadow u_shd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_start (word_start),
    .div_in     (div_n),
    .lo_len     (lo_len),
    .hi_len     (hi_len)
  );

  presc_phase_gen u_ph (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .word_start (word_start),
    .lo_len     (lo_len),
    .hi_len     (hi_len),
    .sclk       (sclk),
    .sclk_tick  (sclk_tick)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_sync_n |=> (!sclk && !sclk_tick));
endmodule

// File: tb/sim_sclk_prescaler.sv
module sim_sclk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_ext = 1'b1;
  logic [7:0] div_code = 8'h00;
  logic       word_start = 1'b0;
  logic       run = 1'b0;
  logic       sclk_tick;
  logic       sclk;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  bit   mon_en = 1'b0;
  int   gap = 0;
  int   q_gap[$];
  logic q_lvl[$];
  string q_req[$];

  always #5 clk = ~clk;

  sclk_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .fmt_ext(fmt_ext), .div_code(div_code),
    .word_start(word_start), .run(run), .sclk_tick(sclk_tick), .sclk(sclk)
  );

  function automatic int exp_div(bit ext, logic [7:0] c);
    int f;
    int e;
    if (ext) begin
      f = int'(c[3:0]);
      if (f < 2) f = 2;
      e = int'({c[7], c[6], c[4]});
      return f << e;
    end
    if (!c[4] || c[3:0] < 4'd2) return 4;
    return 2 * int'(c[3:0]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      gap = gap + 1;
      if (sclk_tick) begin
        if (q_gap.size() == 0) begin
          check(1'b0, "R7 unexpected tick", gap, -1);
        end else begin
          int   eg;
          logic el;
          string er;
          eg = q_gap.pop_front();
          el = q_lvl.pop_front();
          er = q_req.pop_front();
          check((gap == eg) && (sclk == el), er, gap * 2 + int'(sclk), eg * 2 + int'(el));
        end
        gap = 0;
      end
      if (word_start) gap = -1;
    end
  end

  // driver: called at posedge+1; ends at posedge+1
  task automatic do_word(bit ext, logic [7:0] code, logic [7:0] mid,
                         int ntog, bit restart_next, string req);
    int n;
    int lo;
    int hi;
    int sum;
    int nxt;
    n   = exp_div(ext, code);
    lo  = (n + 1) / 2;
    hi  = n / 2;
    sum = 0;
    fmt_ext    = ext;
    div_code   = code;
    word_start = 1'b1;
    run        = 1'b1;
    for (int i = 0; i < ntog; i++) begin
      int g;
      g = (i % 2 == 0) ? lo : hi;
      q_gap.push_back(g);
      q_lvl.push_back((i % 2 == 0) ? 1'b1 : 1'b0);
      q_req.push_back(req);
      sum += g;
    end
    nxt = (ntog % 2 == 0) ? lo : hi;
    @(posedge clk); #1;
    word_start = 1'b0;
    div_code   = mid;
    repeat (sum + nxt - 1) @(posedge clk);
    #1;
    if (!restart_next) begin
      run = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check(!sclk && !sclk_tick, "R9 idle after run low", int'(sclk), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(!sclk && !sclk_tick, "R1 reset state", int'(sclk) + int'(sclk_tick), 0);
    mon_en = 1'b1;

    do_word(1'b1, 8'h05, 8'h0F, 4, 1'b0, "R2 R6 R8 odd N=5");
    do_word(1'b1, 8'h63, 8'h01, 3, 1'b1, "R2 bit5 ignored N=12");
    do_word(1'b1, 8'h01, 8'h00, 5, 1'b1, "R3 R10 N=2 restart");
    do_word(1'b1, 8'h10, 8'hDF, 2, 1'b0, "R3 R9 N=4 drop");
    do_word(1'b1, 8'h9B, 8'h05, 2, 1'b0, "R2 split exponent N=352");
    do_word(1'b0, 8'h1F, 8'h12, 2, 1'b0, "R4 legacy N=30");
    do_word(1'b0, 8'hF7, 8'h1F, 3, 1'b1, "R4 upper bits ignored N=14");
    do_word(1'b0, 8'h0C, 8'h1F, 2, 1'b1, "R5 flag clear N=4");
    do_word(1'b0, 8'h11, 8'h1F, 3, 1'b0, "R5 half below 2 N=4");
    do_word(1'b0, 8'h15, 8'hDF, 3, 1'b0, "R4 R8 legacy N=10");
    do_word(1'b1, 8'hDF, 8'h00, 2, 1'b0, "R11 max N=1920");

    repeat (4) @(posedge clk);
    #1;
    check(q_gap.size() == 0, "R6 all expected edges seen", q_gap.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule